// File: doc/BRIEF.md
# Serial Keyboard Host Receiver

This block sits on the host side of a two-wire keyboard link. One wire comes back from the keyboard, already inverted by an external comparator and already synchronous to the system clock. That wire first acts as a "character waiting" flag and then carries the serial data. The other wire is a shift clock that the host alone drives.

When the flag goes high and the local keystroke queue has room, the block sends a one-cycle acknowledge pulse and then a burst of eight clock pulses. It samples one bit at each rising clock edge, least significant bit first. The assembled byte goes into a 16-entry FIFO, and the CPU side drains it through a valid/ready pop port.

After a byte is complete, the block will not start another read until the keyboard releases the line. If the FIFO is full, the block leaves the keyboard holding its character until an entry is popped.

Top module: `kbd_serial_host`

## Requirements
- R1: After reset, the shift clock and acknowledge are low, empty is 1, full is 0 and valid is 0.
- R2: A read begins only while the block is idle and the incoming line is high. A low line never produces an acknowledge or clock pulses.
- R3: Each read starts with an acknowledge that is high for exactly one system clock. The shift clock is low during that cycle and rises only afterwards.
- R4: Each read produces exactly eight shift-clock pulses. Each high phase lasts HI_CYC system clocks and each low phase between pulses lasts LO_CYC system clocks.
- R5: The line level seen at the k-th rising shift-clock edge (k = 0..7) becomes record bit k. Record bits [5:0] hold the keycode, bit 6 the shift status and bit 7 the control status.
- R6: Completed records leave the FIFO in arrival order, and the FIFO holds up to 16 of them.
- R7: While the FIFO is full, no read starts. A waiting character is read once an entry has been popped.
- R8: After a record is complete, no new read starts until the incoming line has been seen low.
- R9: rd_valid_o equals NOT empty_o. While valid is high and ready is low, the output data stays unchanged.
- R10: full_o is 1 exactly when 16 records are stored, and full and empty are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kb_line_i | input | 1 | Inverted keyboard line: high means a key is waiting; during a read it carries the data bits |
| kb_clk_o | output | 1 | Shift clock driven to the keyboard |
| kb_ack_o | output | 1 | One-cycle acknowledge/reset pulse to the keyboard at the start of a read |
| rd_data_o | output | 8 | Oldest queued record |
| rd_valid_o | output | 1 | A record is available |
| rd_ready_i | input | 1 | Consumer accepts the record when high together with valid |
| full_o | output | 1 | FIFO holds 16 records |
| empty_o | output | 1 | FIFO holds no record |

## Verification
The assertions check the following on every cycle:
- the acknowledge shape and its placement before the first clock edge;
- that a read is never started against a low line or a full queue;
- the high-phase width of every shift-clock pulse;
- the flag consistency and data hold on the pop port.

Only the bench scenarios can show the rest:
- the bit order and field placement of assembled records;
- first-in first-out ordering across a full queue;
- the stall and later resumption of a keyboard held off by a full queue;
- the refusal to re-arm while the line stays high after a record.

// File: rtl/kbd_serial_host.sv
module kbd_serial_host #(
  parameter int DEPTH  = 16,
  parameter int REC_W  = 8,
  parameter int HI_CYC = 4,
  parameter int LO_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kb_line_i,
  output logic             kb_clk_o,
  output logic             kb_ack_o,
  output logic [REC_W-1:0] rd_data_o,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output logic             full_o,
  output logic             empty_o
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int PMAX = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
  localparam int PW   = $clog2(PMAX + 1);
  localparam int BW   = $clog2(REC_W + 1);

  typedef enum logic [2:0] {S_IDLE, S_ACK, S_LO, S_HI, S_WAIT} st_t;

  st_t              st;
  logic [PW-1:0]    ph;
  logic [BW-1:0]    nbits;
  logic [REC_W-1:0] sh;
  logic [REC_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CNTW-1:0]  cnt;
  logic             push, pop, busy;

  assign push       = (st == S_HI) && (ph == '0) && (nbits == BW'(REC_W));
  assign pop        = rd_valid_o && rd_ready_i;
  assign full_o     = (cnt == CNTW'(DEPTH));
  assign empty_o    = (cnt == '0);
  assign rd_valid_o = !empty_o;
  assign rd_data_o  = mem[rptr];
  assign kb_ack_o   = (st == S_ACK);
  assign busy       = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= '0;
      nbits    <= '0;
      sh       <= '0;
      kb_clk_o <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (kb_line_i && !full_o) begin
          st    <= S_ACK;
          nbits <= '0;
        end
        S_ACK: begin
          st <= S_LO;
          ph <= PW'(LO_CYC - 1);
        end
        S_LO: if (ph == '0) begin
          st       <= S_HI;
          kb_clk_o <= 1'b1;
          sh       <= {kb_line_i, sh[REC_W-1:1]};
          nbits    <= nbits + 1'b1;
          ph       <= PW'(HI_CYC - 1);
        end else begin
          ph <= ph - 1'b1;
        end
        S_HI: if (ph == '0) begin
          kb_clk_o <= 1'b0;
          if (nbits == BW'(REC_W)) begin
            st <= S_WAIT;
          end else begin
            st <= S_LO;
            ph <= PW'(LO_CYC - 1);
          end
        end else begin
          ph <= ph - 1'b1;
        end
        S_WAIT: if (!kb_line_i) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= sh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      cnt <= cnt + CNTW'(push) - CNTW'(pop);
    end
  end
endmodule

// File: rtl/kbd_serial_host_chk.sv
module kbd_serial_host_chk #(
  parameter int REC_W  = 8,
  parameter int HI_CYC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             kb_line_i,
  input logic             kb_clk_o,
  input logic             kb_ack_o,
  input logic [REC_W-1:0] rd_data_o,
  input logic             rd_valid_o,
  input logic             rd_ready_i,
  input logic             full_o,
  input logic             empty_o,
  input logic             busy
);
  localparam int HW = $clog2(HI_CYC + 2);
  logic [HW-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) hcnt <= '0;
    else if (kb_clk_o) hcnt <= (hcnt == HW'(HI_CYC + 1)) ? hcnt : hcnt + 1'b1;
    else hcnt <= '0;
  end

  // R3
  ack_one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kb_ack_o |=> !kb_ack_o);
  // R3
  ack_before_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kb_ack_o |-> !kb_clk_o);
  // R2
  start_needs_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kb_ack_o |-> $past(kb_line_i));
  // R7
  no_start_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kb_ack_o |-> !$past(full_o));
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !kb_clk_o);
  // R4
  hi_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(kb_clk_o) |-> hcnt == HW'(HI_CYC));
  // R10
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o));
  // R9
  valid_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o == !empty_o);
  // R9
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o));
endmodule

bind kbd_serial_host kbd_serial_host_chk #(.REC_W(REC_W), .HI_CYC(HI_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .kb_line_i(kb_line_i), .kb_clk_o(kb_clk_o),
  .kb_ack_o(kb_ack_o), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
  .rd_ready_i(rd_ready_i), .full_o(full_o), .empty_o(empty_o), .busy(busy));

// File: tb/sim_kbd_serial_host.sv
`timescale 1ns/1ps
module sim_kbd_serial_host;
  localparam int HI = 3;
  localparam int LO = 2;
  localparam int NV = 6;
  localparam logic [7:0] VEC [NV] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81, 8'h5A};

  logic clk = 0, rst_n = 0, line = 0, rdy = 0;
  logic kclk, ack, valid, full, empty;
  logic [7:0] data;
  int total = 0, bad = 0;
  int bad_hi = 0, bad_lo = 0, npulse = 0;

  always #2.5 clk = ~clk;

  kbd_serial_host #(.DEPTH(16), .REC_W(8), .HI_CYC(HI), .LO_CYC(LO)) u0 (
    .clk(clk), .rst_n(rst_n), .kb_line_i(line), .kb_clk_o(kclk), .kb_ack_o(ack),
    .rd_data_o(data), .rd_valid_o(valid), .rd_ready_i(rdy), .full_o(full), .empty_o(empty));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic kb_send(input logic [7:0] code, input bit stick);
    line = 1;
    while (!ack) @(negedge clk);
    @(negedge clk);
    line = code[0];
    for (int i = 0; i < 8; i++) begin
      int h, l;
      while (!kclk) @(negedge clk);
      npulse++;
      h = 0;
      while (kclk) begin h++; @(negedge clk); end
      if (h != HI) bad_hi++;
      line = (i < 7) ? code[i+1] : stick;
      if (i < 7) begin
        l = 0;
        while (!kclk) begin l++; @(negedge clk); end
        if (l != LO) bad_lo++;
      end
    end
  endtask

  task automatic pop_chk(input logic [7:0] exp, input string req);
    int t = 0;
    while (!valid && t < 2000) begin t++; @(negedge clk); end
    chk(valid && data == exp, req, data, exp);
    rdy = 1;
    @(negedge clk);
    rdy = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!kclk && !ack && empty && !full && !valid, "R1", {kclk, ack, empty, full, valid}, 5'b00100);
    rst_n = 1;
    // R2 low line: no activity
    n = 0;
    repeat (50) begin @(negedge clk); if (ack || kclk) n++; end
    chk(n == 0, "R2", n, 0);

    // R5 R6 vector table, LSB first
    foreach (VEC[i]) begin
      npulse = 0;
      kb_send(VEC[i], 0);
      chk(npulse == 8, "R4 pulses", npulse, 8);
      pop_chk(VEC[i], "R5");
    end
    chk(bad_hi == 0 && bad_lo == 0, "R4 widths", bad_hi + bad_lo, 0);

    // R5 fields: keycode 0x2B, shift=1, ctrl=0
    kb_send(8'h6B, 0);
    repeat (2) @(negedge clk);
    chk(data[5:0] == 6'h2B && data[6] && !data[7], "R5 fields", data, 8'h6B);
    // R9 hold while not ready
    repeat (5) @(negedge clk);
    chk(valid && data == 8'h6B, "R9 hold", data, 8'h6B);
    pop_chk(8'h6B, "R9");
    chk(empty && !valid, "R9 empty", valid, 0);

    // R6 R10 fill 16
    for (int k = 0; k < 16; k++) begin
      kb_send(8'h10 + 8'(k), 0);
      @(negedge clk);
      if (k == 14) chk(!full, "R10 at 15", full, 0);
    end
    chk(full && !empty, "R10 full", full, 1);
    // R7 held off while full
    fork kb_send(8'hE7, 0); join_none
    n = 0;
    repeat (100) begin @(negedge clk); if (ack || kclk) n++; end
    chk(n == 0, "R7 stall", n, 0);
    pop_chk(8'h10, "R6 order");
    n = 0;
    while (!(valid && full) && n < 500) begin n++; @(negedge clk); end
    repeat (4) @(negedge clk);
    chk(full, "R7 resume", full, 1);
    for (int k = 1; k < 16; k++) pop_chk(8'h10 + 8'(k), "R6 order");
    pop_chk(8'hE7, "R7 data");
    chk(empty, "R10 empty", empty, 1);

    // R8 line stays high after record
    kb_send(8'h33, 1);
    n = 0;
    repeat (60) begin @(negedge clk); if (ack || kclk) n++; end
    chk(n == 0, "R8 no rearm", n, 0);
    line = 0;
    repeat (3) @(negedge clk);
    kb_send(8'hC4, 0);
    pop_chk(8'h33, "R8 first");
    pop_chk(8'hC4, "R8 rearm");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule